// File: doc/BRIEF.md
# Time-Division Inter-Chip Signal Multiplexer

This block moves a wide bus from one part of a partitioned design to another over a small number of physical lines. It does this by sharing each line in time, using a mux clock that runs several times faster than the main clock. Every main clock period is one frame. A frame strobe, generated in the mux-clock domain, marks the start of each frame and pulls both ends of the link to slot 0. Both ends keep their own slot counters, so they stay aligned without exchanging any other control signal.

Within a frame, the sender first takes a snapshot of its source bus. It then uses one cycle to let that snapshot settle on the line registers. After that, it places one slice per line per cycle on the lines. The receiver writes each slice into its own holding register. In the last reserved cycle it copies the assembled bus to its output and raises a one-cycle valid pulse, so the output is complete by the next main clock edge.

Two link directions are built from identical halves. There is no back-pressure: the frame timing is fixed, so the input has no ready signal and the output valid pulse cannot be stalled. A configuration in which the slot count plus two exceeds the clock ratio is rejected at elaboration.

Top module: `tdm_link`

## Requirements
- R1: While reset is asserted, and after reset until the first frame strobe, every line output, every output bus and both valid flags are zero.
- R2: When the frame strobe is sampled high, both slot counters restart. The lines carry slot 0 in the first mux cycle after the next edge, which is the cycle after the settle cycle.
- R3: On each line, slot s occupies the (s+2)-th mux cycle after the strobe edge. Line l in slot s carries bus bit s*LANES+l, so slot 0 carries the lowest LANES bits.
- R4: The source bus is captured at the strobe edge. Changes to the source after that edge do not alter any slice sent in that frame.
- R5: SLOTS+2 mux edges after the strobe edge, the output bus equals the source bus captured at that strobe, and valid is high. With the default ratio, this is the edge at which the next frame starts.
- R6: Valid stays high for exactly one cycle per frame. The output bus changes only in the cycle in which valid is high.
- R7: If no further strobe arrives, the counters stop after the last phase. The lines then stay at zero, valid stays low, and the output bus keeps its last value.
- R8: A strobe that arrives before a frame is finished discards that frame. No valid pulse is produced for it, and the new frame proceeds from slot 0.
- R9: The reverse direction has the same timing and mapping as the forward direction, and carries its own bus independently.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Mux clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_sync | input | 1 | One-cycle strobe marking each main-clock frame start |
| fwd_data_in | input | LANES*SLOTS | Forward source bus |
| rev_data_in | input | LANES*SLOTS | Reverse source bus |
| fwd_line | output | LANES | Forward time-shared lines |
| rev_line | output | LANES | Reverse time-shared lines |
| fwd_data_out | output | LANES*SLOTS | Forward reassembled bus |
| fwd_valid | output | 1 | Forward frame-complete pulse |
| rev_data_out | output | LANES*SLOTS | Reverse reassembled bus |
| rev_valid | output | 1 | Reverse frame-complete pulse |

## Verification
Frames are sent back to back with several bus patterns: all ones, a single low bit, a single high bit, alternating bits and random values. The single-bit patterns show whether slots are in the wrong order or lines are swapped. The alternating and random patterns show whether lines are merged. Both directions carry different values at the same time, so any cross-talk between them shows up. In some frames the source bus is inverted right after the strobe, to check that the snapshot is taken at the strobe edge. A frame is also cut short by an early strobe, to check the restart behaviour. Finally, the strobe is withheld, to check that the lines go quiet and the output bus holds.

// File: rtl/tdm_pkg.sv
package tdm_pkg;
  // bits needed to hold phases 0..ratio, where ratio itself is the idle code
  function automatic int phase_width(input int ratio);
    return $clog2(ratio + 1);
  endfunction
endpackage

// File: rtl/tdm_slot_ctr.sv
module tdm_slot_ctr #(
  parameter int RATIO = 10,
  parameter int PW    = tdm_pkg::phase_width(RATIO)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sync,
  output logic [PW-1:0] phase
);
  localparam logic [PW-1:0] IDLE = PW'(RATIO);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             phase <= IDLE;
    else if (sync)          phase <= '0;
    else if (phase != IDLE) phase <= phase + PW'(1);
  end

  assert_sync_realign_R2: assert property (@(posedge clk) disable iff (!rst_n)
    sync |=> phase == '0);
  assert_phase_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!sync && phase != IDLE) |=> phase == $past(phase) + PW'(1));
  assert_idle_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!sync && phase == IDLE) |=> phase == IDLE);
endmodule

// File: rtl/tdm_tx.sv
module tdm_tx #(
  parameter int LANES = 2,
  parameter int SLOTS = 8,
  parameter int RATIO = 10
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   sync,
  input  logic [LANES*SLOTS-1:0] data_in,
  output logic [LANES-1:0]       lines
);
  localparam int W  = LANES * SLOTS;
  localparam int PW = tdm_pkg::phase_width(RATIO);

  logic [PW-1:0]    phase;
  logic [W-1:0]     shadow;
  logic [LANES-1:0] slice [SLOTS];
  logic [LANES-1:0] pick;

  tdm_slot_ctr #(.RATIO(RATIO), .PW(PW)) u_ctr (
    .clk(clk), .rst_n(rst_n), .sync(sync), .phase(phase)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    shadow <= '0;
    else if (sync) shadow <= data_in;
  end

  for (genvar s = 0; s < SLOTS; s++) begin : g_slice
    assign slice[s] = shadow[s*LANES +: LANES];
  end

  // N:1 select per line, decoded from the slot counter
  always_comb begin
    pick = '0;
    for (int s = 0; s < SLOTS; s++)
      if (phase == PW'(s)) pick = slice[s];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lines <= '0;
    else        lines <= pick;
  end

  assert_shadow_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !sync |=> $stable(shadow));
  assert_line_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (phase >= PW'(SLOTS)) |=> lines == '0);
endmodule

// File: rtl/tdm_rx.sv
module tdm_rx #(
  parameter int LANES = 2,
  parameter int SLOTS = 8,
  parameter int RATIO = 10
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   sync,
  input  logic [LANES-1:0]       lines,
  output logic [LANES*SLOTS-1:0] data_out,
  output logic                   valid
);
  localparam int W  = LANES * SLOTS;
  localparam int PW = tdm_pkg::phase_width(RATIO);

  logic [PW-1:0] phase;
  logic [W-1:0]  hold;

  if (SLOTS + 2 > RATIO) begin : g_bad_ratio
    $error("tdm_rx: SLOTS+2 must not exceed RATIO");
  end

  tdm_slot_ctr #(.RATIO(RATIO), .PW(PW)) u_ctr (
    .clk(clk), .rst_n(rst_n), .sync(sync), .phase(phase)
  );

  // slot s is on the lines during phase s+1
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hold <= '0;
    else
      for (int s = 0; s < SLOTS; s++)
        if (phase == PW'(s + 1)) hold[s*LANES +: LANES] <= lines;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_out <= '0;
      valid    <= 1'b0;
    end else if (phase == PW'(SLOTS + 1)) begin
      data_out <= hold;
      valid    <= 1'b1;
    end else begin
      valid    <= 1'b0;
    end
  end

  assert_valid_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
    valid |=> !valid);
  assert_out_on_valid_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (data_out != $past(data_out)) |-> valid);
endmodule

// File: rtl/tdm_link.sv
module tdm_link #(
  parameter int LANES = 2,
  parameter int SLOTS = 8,
  parameter int RATIO = 10
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   frame_sync,
  input  logic [LANES*SLOTS-1:0] fwd_data_in,
  input  logic [LANES*SLOTS-1:0] rev_data_in,
  output logic [LANES-1:0]       fwd_line,
  output logic [LANES-1:0]       rev_line,
  output logic [LANES*SLOTS-1:0] fwd_data_out,
  output logic                   fwd_valid,
  output logic [LANES*SLOTS-1:0] rev_data_out,
  output logic                   rev_valid
);
  tdm_tx #(.LANES(LANES), .SLOTS(SLOTS), .RATIO(RATIO)) u_fwd_tx (
    .clk(clk), .rst_n(rst_n), .sync(frame_sync),
    .data_in(fwd_data_in), .lines(fwd_line)
  );
  tdm_rx #(.LANES(LANES), .SLOTS(SLOTS), .RATIO(RATIO)) u_fwd_rx (
    .clk(clk), .rst_n(rst_n), .sync(frame_sync),
    .lines(fwd_line), .data_out(fwd_data_out), .valid(fwd_valid)
  );
  tdm_tx #(.LANES(LANES), .SLOTS(SLOTS), .RATIO(RATIO)) u_rev_tx (
    .clk(clk), .rst_n(rst_n), .sync(frame_sync),
    .data_in(rev_data_in), .lines(rev_line)
  );
  tdm_rx #(.LANES(LANES), .SLOTS(SLOTS), .RATIO(RATIO)) u_rev_rx (
    .clk(clk), .rst_n(rst_n), .sync(frame_sync),
    .lines(rev_line), .data_out(rev_data_out), .valid(rev_valid)
  );
endmodule

// File: tb/sim_tdm_link.sv
module sim_tdm_link;
  localparam int LANES = 2;
  localparam int SLOTS = 8;
  localparam int RATIO = 10;
  localparam int W     = LANES * SLOTS;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic             rst_n, frame_sync;
  logic [W-1:0]     fwd_in, rev_in, fwd_out, rev_out;
  logic [LANES-1:0] fwd_line, rev_line;
  logic             fwd_valid, rev_valid;

  int compared = 0, mismatched = 0;
  bit done = 1'b0;
  bit have_prev = 1'b0;
  logic [W-1:0] prev_f, prev_r;

  tdm_link #(.LANES(LANES), .SLOTS(SLOTS), .RATIO(RATIO)) u0 (
    .clk(clk), .rst_n(rst_n), .frame_sync(frame_sync),
    .fwd_data_in(fwd_in), .rev_data_in(rev_in),
    .fwd_line(fwd_line), .rev_line(rev_line),
    .fwd_data_out(fwd_out), .fwd_valid(fwd_valid),
    .rev_data_out(rev_out), .rev_valid(rev_valid)
  );

  task automatic check(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  // entered and left at a negedge; leaves the next strobe to the caller
  task automatic frame(input logic [W-1:0] a, input logic [W-1:0] b, input bit scramble);
    frame_sync = 1'b1; fwd_in = a; rev_in = b;
    @(negedge clk);
    frame_sync = 1'b0;
    if (scramble) begin fwd_in = ~a; rev_in = a ^ b ^ 16'h5a5a; end
    if (have_prev) begin
      check("R5 fwd valid", W'(fwd_valid), W'(1));
      check("R5 fwd data", fwd_out, prev_f);
      check("R9 rev valid", W'(rev_valid), W'(1));
      check("R9 rev data", rev_out, prev_r);
    end
    for (int k = 1; k < RATIO; k++) begin
      @(negedge clk);
      check("R6 fwd valid low", W'(fwd_valid), W'(0));
      check("R9 rev valid low", W'(rev_valid), W'(0));
      if (k <= SLOTS) begin
        check(k == 1 ? "R2 first slot" : (scramble ? "R4 slot" : "R3 slot"),
              W'(fwd_line), W'(a[(k-1)*LANES +: LANES]));
        check("R9 rev slot", W'(rev_line), W'(b[(k-1)*LANES +: LANES]));
      end else begin
        check("R7 fwd quiet slot", W'(fwd_line), W'(0));
      end
    end
    prev_f = a; prev_r = b; have_prev = 1'b1;
  endtask

  task automatic drain();
    frame_sync = 1'b0;
    @(negedge clk);
    check("R5 last fwd valid", W'(fwd_valid), W'(1));
    check("R5 last fwd data", fwd_out, prev_f);
    check("R9 last rev data", rev_out, prev_r);
    @(negedge clk);
    check("R6 valid drops", W'(fwd_valid), W'(0));
    check("R6 data holds", fwd_out, prev_f);
    have_prev = 1'b0;
  endtask

  task automatic t_reset();
    rst_n = 1'b0; frame_sync = 1'b0; fwd_in = '1; rev_in = '1;
    repeat (3) @(negedge clk);
    check("R1 fwd line in reset", W'(fwd_line), W'(0));
    check("R1 fwd out in reset", fwd_out, '0);
    check("R1 valid in reset", W'(fwd_valid | rev_valid), W'(0));
    rst_n = 1'b1;
    repeat (12) @(negedge clk);
    check("R1 lines before strobe", W'({fwd_line, rev_line}), W'(0));
    check("R1 rev out before strobe", rev_out, '0);
    check("R1 valid before strobe", W'(fwd_valid | rev_valid), W'(0));
  endtask

  task automatic t_patterns();
    frame(16'hFFFF, 16'h0000, 1'b0);
    frame(16'h0001, 16'h8000, 1'b0);
    frame(16'h8000, 16'h0001, 1'b0);
    frame(16'hAAAA, 16'h5555, 1'b0);
    for (int i = 0; i < 6; i++) frame(W'($urandom), W'($urandom), 1'b0);
    drain();
  endtask

  task automatic t_scramble();
    frame(16'h1234, 16'hC3A5, 1'b1);
    frame(16'hF00F, 16'h0FF0, 1'b1);
    drain();
    check("R4 captured at strobe", fwd_out, 16'hF00F);
  endtask

  task automatic t_idle();
    for (int i = 0; i < 3 * RATIO; i++) begin
      @(negedge clk);
      check("R7 idle valid", W'(fwd_valid | rev_valid), W'(0));
      check("R7 idle lines", W'({fwd_line, rev_line}), W'(0));
      check("R7 idle out holds", fwd_out, prev_f);
    end
  endtask

  task automatic t_resync();
    frame_sync = 1'b1; fwd_in = 16'hDEAD; rev_in = 16'hBEEF;
    @(negedge clk);
    frame_sync = 1'b0;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      check("R8 no valid partial", W'(fwd_valid), W'(0));
    end
    have_prev = 1'b0;
    frame(16'h0F0F, 16'h3C3C, 1'b0);
    drain();
    check("R8 restarted frame", fwd_out, 16'h0F0F);
    check("R9 restarted rev", rev_out, 16'h3C3C);
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      mismatched++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_patterns();
    t_scramble();
    t_idle();
    t_resync();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule